// File: doc/BRIEF.md
# Parallel TLB and Cache-Tag Hit Unit

This block is the lookup stage of a set-associative data cache that sits behind a set-associative translation buffer. When a request arrives, one translation set and one cache-tag set are read in the same cycle, both indexed by address bits that translation does not change. A grid of comparators then matches every translation way's physical page number against every cache way's stored tag. The translation way that hits picks which row of comparison results is used. Translation therefore never sits in series with the cache tag compare.

The response comes two cycles after the request. It gives a combined hit, a translation-miss flag and a cache-miss flag, so that a refill engine can tell the two miss kinds apart. It also gives the hitting cache way and the data word read from a data RAM with a registered output. A request can run in physical mode. In that mode the translation result is ignored, the page number is taken from the address itself, and only comparator row 0 counts.

Loading the arrays is done through two plain write ports, one for translation entries and one for cache lines. Refill sequencing, permission checks and table walks belong to other blocks.

Top module: `xlat_tag_lookup`

## Requirements
- R1: Reset clears every translation and tag valid bit and drops `rsp_valid`. A translated lookup issued right after reset reports a translation miss, and a physical-mode lookup reports a cache miss.
- R2: A request sampled at clock edge k produces its response, with `rsp_valid` high for exactly one cycle, in the cycle that follows edge k+1. Back-to-back requests give back-to-back responses.
- R3: A translated hit works as follows. The translation set is address bits [15:12] and the translation tag is bits [31:16]. When a valid entry in that set matches, its 20-bit page number is compared with the valid cache tags of set address[8:3]. A match gives `rsp_hit`=1, `rsp_way` = the matching cache way, and `rsp_data` = the word stored for that line.
- R4: When no valid translation entry matches, `rsp_tlb_miss`=1 and `rsp_hit`=`rsp_cache_miss`=0, whatever the cache tags hold.
- R5: When translation hits but no valid cache tag equals the translated page number, `rsp_cache_miss`=1 and `rsp_hit`=`rsp_tlb_miss`=0.
- R6: In physical mode (`req_real`=1) the page number is address bits [31:12] and the translation arrays are ignored. Such a lookup never reports a translation miss.
- R7: Only the comparison row of the hitting translation way counts. If another translation way in the same set holds a page number that matches a different cache way, that match does not affect the result.
- R8: A write with the valid bit low removes an entry, and an invalid entry never matches. A rewrite of a line replaces both its tag and its data. At most one translation way and at most one cache way match per lookup.
- R9: On every response exactly one of `rsp_hit`, `rsp_tlb_miss` and `rsp_cache_miss` is high, and all three are low between responses. On a miss `rsp_way` and `rsp_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Lookup address (virtual, or physical in physical mode) |
| req_real | input | 1 | Physical-mode lookup, translation bypassed |
| tlb_wr_en | input | 1 | Translation entry write strobe |
| tlb_wr_way | input | idx_w(N_TLB) | Translation way to write |
| tlb_wr_vaddr | input | ADDR_W | Virtual address giving set and tag of the entry |
| tlb_wr_ppn | input | ADDR_W-PG_W | Physical page number of the entry |
| tlb_wr_valid | input | 1 | Valid bit written with the entry |
| tag_wr_en | input | 1 | Cache line write strobe (tag and data) |
| tag_wr_way | input | idx_w(M_CACHE) | Cache way to write |
| tag_wr_paddr | input | ADDR_W | Physical address giving set and tag of the line |
| tag_wr_valid | input | 1 | Valid bit written with the tag |
| tag_wr_data | input | DATA_W | Data word stored for the line |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Translation and cache both hit |
| rsp_tlb_miss | output | 1 | No translation entry matched |
| rsp_cache_miss | output | 1 | Translation hit, no cache way matched |
| rsp_way | output | idx_w(M_CACHE) | Hitting cache way, zero on a miss |
| rsp_data | output | DATA_W | Data of the hitting line, zero on a miss |

## Verification
The comparator grid is tested with addresses that isolate each outcome. A translated address whose entry sits in translation way 0, and one whose entry sits in way 1, show that the hit way picks its own row. A set where the non-hitting translation way's page number matches a cache tag shows that row selection is real and not an OR over all rows. Addresses whose translation tag is absent from the set separate translation misses from cache misses. Physical-mode addresses show that the translation arrays are bypassed, including one whose translated form would have hit. A random stream, checked against a separate model of the arrays, mixes all these cases back to back. Invalidation and rewrite cases then show that valid bits and line data are updated.

// File: rtl/xl_lookup_pkg.sv
// Shared helpers and types for the parallel translation/tag lookup unit.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package xl_lookup_pkg;

    // Width of a way index; a single way still gets a one-bit field.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Outcome of one lookup; at most one member is set.
    typedef struct packed {
        logic hit;
        logic tlb_miss;
        logic cache_miss;
    } lk_outcome_t;

    localparam lk_outcome_t LK_IDLE = '{hit: 1'b0, tlb_miss: 1'b0, cache_miss: 1'b0};

endpackage

// File: rtl/xl_set_store.sv
// Set-associative entry store with a valid bit per entry.
// One write port and one synchronous read port that returns a whole set.
// Valid bits are reset; payloads are not. A read and a write to the
// same entry in the same cycle return the old contents.
module xl_set_store
    import xl_lookup_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int SET_W = 4,
    parameter int ENT_W = 36
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [SET_W-1:0]             rd_set,
    input  logic                         wr_en,
    input  logic [idx_w(WAYS)-1:0]       wr_way,
    input  logic [SET_W-1:0]             wr_set,
    input  logic                         wr_valid,
    input  logic [ENT_W-1:0]             wr_ent,
    output logic [WAYS-1:0]              rd_valid,
    output logic [WAYS-1:0][ENT_W-1:0]   rd_ent
);
    localparam int SETS = 1 << SET_W;
    localparam int WW   = idx_w(WAYS);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]  vld_q;
        logic [ENT_W-1:0] ent_mem [SETS];
        logic             v_q;
        logic [ENT_W-1:0] e_q;
        logic             sel;

        assign sel = wr_en && (wr_way == WW'(w));

        // Valid-bit update for this way.
        always_ff @(posedge clk) begin
            if (!rst_n)   vld_q <= '0;
            else if (sel) vld_q[wr_set] <= wr_valid;
        end

        // Payload write for this way.
        always_ff @(posedge clk) begin
            if (sel) ent_mem[wr_set] <= wr_ent;
        end

        // Registered read of the valid bit.
        always_ff @(posedge clk) begin
            if (!rst_n)     v_q <= 1'b0;
            else if (rd_en) v_q <= vld_q[rd_set];
        end

        // Registered read of the payload.
        always_ff @(posedge clk) begin
            if (rd_en) e_q <= ent_mem[rd_set];
        end

        assign rd_valid[w] = v_q;
        assign rd_ent[w]   = e_q;
    end

endmodule

// File: rtl/xl_data_ram.sv
// Per-way data RAM with a synchronous read and an extra output register.
// The output register is the second pipeline stage; it is kept inside
// this wrapper so that it maps onto a block RAM's own output register.
// No reset: contents and read registers are don't-care until written.
module xl_data_ram
    import xl_lookup_pkg::*;
#(
    parameter int WAYS   = 2,
    parameter int SET_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [idx_w(WAYS)-1:0]       wr_way,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         rd_en,
    input  logic [SET_W-1:0]             rd_set,
    input  logic                         out_en,
    output logic [WAYS-1:0][DATA_W-1:0]  rd_data
);
    localparam int SETS = 1 << SET_W;
    localparam int WW   = idx_w(WAYS);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [DATA_W-1:0] mem [SETS];
        logic [DATA_W-1:0] rd_q;
        logic [DATA_W-1:0] out_q;

        // Line data write.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == WW'(w))) mem[wr_set] <= wr_data;
        end

        // First read stage: array access.
        always_ff @(posedge clk) begin
            if (rd_en) rd_q <= mem[rd_set];
        end

        // Second read stage: output register.
        always_ff @(posedge clk) begin
            if (out_en) out_q <= rd_q;
        end

        assign rd_data[w] = out_q;
    end

endmodule

// File: rtl/xl_match_grid.sv
// Comparator grid: one comparator per (translation way, cache way) pair
// checks that way's page number against that cache tag, all in parallel.
// The hitting translation way selects its row of results. In physical
// mode row 0 compares the address page number and is always selected.
// Assumes at most one translation way and one cache way match.
module xl_match_grid
    import xl_lookup_pkg::*;
#(
    parameter int N_TLB   = 2,
    parameter int M_CACHE = 2,
    parameter int VTAG_W  = 16,
    parameter int PPN_W   = 20
) (
    input  logic                                  lk_valid,
    input  logic                                  lk_real,
    input  logic [VTAG_W-1:0]                     lk_vtag,
    input  logic [PPN_W-1:0]                      lk_ppn,
    input  logic [N_TLB-1:0]                      tlb_valid,
    input  logic [N_TLB-1:0][VTAG_W+PPN_W-1:0]    tlb_ent,
    input  logic [M_CACHE-1:0]                    tag_valid,
    input  logic [M_CACHE-1:0][PPN_W-1:0]         tag_ent,
    output logic [N_TLB-1:0]                      tlb_way_hit,
    output logic [M_CACHE-1:0]                    cache_way_hit,
    output lk_outcome_t                           outcome,
    output logic [idx_w(M_CACHE)-1:0]             hit_way
);
    localparam int CW = idx_w(M_CACHE);

    logic [N_TLB-1:0][M_CACHE-1:0] cmp;
    logic [M_CACHE-1:0]            row_sel;
    logic                          tlb_hit;
    logic                          any_way;

    for (genvar n = 0; n < N_TLB; n++) begin : g_row
        logic [VTAG_W-1:0] ent_vtag;
        logic [PPN_W-1:0]  ent_ppn;
        logic [PPN_W-1:0]  row_ppn;

        assign ent_vtag = tlb_ent[n][PPN_W +: VTAG_W];
        assign ent_ppn  = tlb_ent[n][PPN_W-1:0];

        assign tlb_way_hit[n] = lk_valid && !lk_real && tlb_valid[n]
                                && (ent_vtag == lk_vtag);

        if (n == 0) begin : g_phys
            assign row_ppn = lk_real ? lk_ppn : ent_ppn;
        end else begin : g_virt
            assign row_ppn = ent_ppn;
        end

        for (genvar m = 0; m < M_CACHE; m++) begin : g_col
            assign cmp[n][m] = tag_valid[m] && (tag_ent[m] == row_ppn);
        end
    end

    // Pick the comparison row belonging to the hitting translation way.
    always_comb begin
        row_sel = '0;
        if (lk_real) begin
            row_sel = cmp[0];
        end else begin
            for (int n = 0; n < N_TLB; n++) begin
                if (tlb_way_hit[n]) row_sel = row_sel | cmp[n];
            end
        end
    end

    assign cache_way_hit = lk_valid ? row_sel : '0;
    assign tlb_hit       = lk_real || (|tlb_way_hit);
    assign any_way       = |cache_way_hit;

    // Classify the lookup.
    always_comb begin
        outcome            = LK_IDLE;
        outcome.hit        = lk_valid && tlb_hit && any_way;
        outcome.tlb_miss   = lk_valid && !tlb_hit;
        outcome.cache_miss = lk_valid && tlb_hit && !any_way;
    end

    // Encode the one-hot cache way hit vector.
    always_comb begin
        hit_way = '0;
        for (int m = 0; m < M_CACHE; m++) begin
            if (cache_way_hit[m]) hit_way = hit_way | CW'(m);
        end
    end

endmodule

// File: rtl/xlat_tag_lookup.sv
// Two-stage lookup: edge k reads the translation set, the tag set and the
// data RAM; cycle k+1 runs the comparator grid from the stage-1 registers;
// edge k+1 registers the outcome and the RAM output, shown in cycle k+2.
// Assumes the cache set index plus line offset fit inside the page offset,
// so both arrays are indexed by untranslated bits.
module xlat_tag_lookup
    import xl_lookup_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PG_W    = 12,
    parameter int TSET_W  = 4,
    parameter int LINE_W  = 3,
    parameter int CSET_W  = 6,
    parameter int N_TLB   = 2,
    parameter int M_CACHE = 2,
    parameter int DATA_W  = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic                         req_real,
    input  logic                         tlb_wr_en,
    input  logic [idx_w(N_TLB)-1:0]      tlb_wr_way,
    input  logic [ADDR_W-1:0]            tlb_wr_vaddr,
    input  logic [ADDR_W-PG_W-1:0]       tlb_wr_ppn,
    input  logic                         tlb_wr_valid,
    input  logic                         tag_wr_en,
    input  logic [idx_w(M_CACHE)-1:0]    tag_wr_way,
    input  logic [ADDR_W-1:0]            tag_wr_paddr,
    input  logic                         tag_wr_valid,
    input  logic [DATA_W-1:0]            tag_wr_data,
    output logic                         rsp_valid,
    output logic                         rsp_hit,
    output logic                         rsp_tlb_miss,
    output logic                         rsp_cache_miss,
    output logic [idx_w(M_CACHE)-1:0]    rsp_way,
    output logic [DATA_W-1:0]            rsp_data
);
    localparam int PPN_W  = ADDR_W - PG_W;
    localparam int VTAG_W = PPN_W - TSET_W;
    localparam int TENT_W = VTAG_W + PPN_W;
    localparam int CW     = idx_w(M_CACHE);

    // Request field split.
    logic [TSET_W-1:0] req_tset;
    logic [CSET_W-1:0] req_cset;
    logic [VTAG_W-1:0] req_vtag;
    logic [PPN_W-1:0]  req_ppn;
    logic              unused_addr;

    assign req_tset    = req_addr[PG_W +: TSET_W];
    assign req_cset    = req_addr[LINE_W +: CSET_W];
    assign req_vtag    = req_addr[ADDR_W-1 -: VTAG_W];
    assign req_ppn     = req_addr[ADDR_W-1 -: PPN_W];
    assign unused_addr = ^{req_addr, tlb_wr_vaddr, tag_wr_paddr};

    // Stage-1 registers.
    logic              s1_valid;
    logic              s1_real;
    logic [VTAG_W-1:0] s1_vtag;
    logic [PPN_W-1:0]  s1_ppn;

    // Stage-1 control capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_real  <= 1'b0;
        end else begin
            s1_valid <= req_valid;
            s1_real  <= req_valid && req_real;
        end
    end

    // Stage-1 address capture.
    always_ff @(posedge clk) begin
        if (req_valid) begin
            s1_vtag <= req_vtag;
            s1_ppn  <= req_ppn;
        end
    end

    // Translation set read.
    logic [N_TLB-1:0]             tlb_valid;
    logic [N_TLB-1:0][TENT_W-1:0] tlb_ent;

    xl_set_store #(
        .WAYS  (N_TLB),
        .SET_W (TSET_W),
        .ENT_W (TENT_W)
    ) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (req_valid),
        .rd_set   (req_tset),
        .wr_en    (tlb_wr_en),
        .wr_way   (tlb_wr_way),
        .wr_set   (tlb_wr_vaddr[PG_W +: TSET_W]),
        .wr_valid (tlb_wr_valid),
        .wr_ent   ({tlb_wr_vaddr[ADDR_W-1 -: VTAG_W], tlb_wr_ppn}),
        .rd_valid (tlb_valid),
        .rd_ent   (tlb_ent)
    );

    // Cache tag set read, concurrent with the translation read.
    logic [M_CACHE-1:0]            tag_valid;
    logic [M_CACHE-1:0][PPN_W-1:0] tag_ent;

    xl_set_store #(
        .WAYS  (M_CACHE),
        .SET_W (CSET_W),
        .ENT_W (PPN_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (req_valid),
        .rd_set   (req_cset),
        .wr_en    (tag_wr_en),
        .wr_way   (tag_wr_way),
        .wr_set   (tag_wr_paddr[LINE_W +: CSET_W]),
        .wr_valid (tag_wr_valid),
        .wr_ent   (tag_wr_paddr[ADDR_W-1 -: PPN_W]),
        .rd_valid (tag_valid),
        .rd_ent   (tag_ent)
    );

    // Data words of all ways, two register stages deep.
    logic [M_CACHE-1:0][DATA_W-1:0] ram_data;

    xl_data_ram #(
        .WAYS   (M_CACHE),
        .SET_W  (CSET_W),
        .DATA_W (DATA_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (tag_wr_en),
        .wr_way  (tag_wr_way),
        .wr_set  (tag_wr_paddr[LINE_W +: CSET_W]),
        .wr_data (tag_wr_data),
        .rd_en   (req_valid),
        .rd_set  (req_cset),
        .out_en  (s1_valid),
        .rd_data (ram_data)
    );

    // Comparator grid working from the current stage-1 state.
    logic [N_TLB-1:0]   tlb_way_hit;
    logic [M_CACHE-1:0] cache_way_hit;
    lk_outcome_t        grid_out;
    logic [CW-1:0]      grid_way;

    xl_match_grid #(
        .N_TLB   (N_TLB),
        .M_CACHE (M_CACHE),
        .VTAG_W  (VTAG_W),
        .PPN_W   (PPN_W)
    ) u_grid (
        .lk_valid      (s1_valid),
        .lk_real       (s1_real),
        .lk_vtag       (s1_vtag),
        .lk_ppn        (s1_ppn),
        .tlb_valid     (tlb_valid),
        .tlb_ent       (tlb_ent),
        .tag_valid     (tag_valid),
        .tag_ent       (tag_ent),
        .tlb_way_hit   (tlb_way_hit),
        .cache_way_hit (cache_way_hit),
        .outcome       (grid_out),
        .hit_way       (grid_way)
    );

    // Stage-2 registers.
    logic        s2_valid;
    lk_outcome_t s2_out;
    logic [CW-1:0] s2_way;

    // Stage-2 capture of the lookup outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_out   <= LK_IDLE;
            s2_way   <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_out   <= grid_out;
            s2_way   <= grid_way;
        end
    end

    assign rsp_valid      = s2_valid;
    assign rsp_hit        = s2_out.hit;
    assign rsp_tlb_miss   = s2_out.tlb_miss;
    assign rsp_cache_miss = s2_out.cache_miss;
    assign rsp_way        = s2_way;
    assign rsp_data       = s2_out.hit ? ram_data[s2_way] : '0;

endmodule

// File: rtl/xlat_tag_lookup_chk.sv
// Property checker for xlat_tag_lookup, attached by the bind below.
// Keeps its own two-deep copy of the request strobe and mode.
module xlat_tag_lookup_chk #(
    parameter int N_TLB   = 2,
    parameter int M_CACHE = 2,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_real,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_tlb_miss,
    input logic               rsp_cache_miss,
    input logic [DATA_W-1:0]  rsp_data,
    input logic [N_TLB-1:0]   tlb_way_hit,
    input logic [M_CACHE-1:0] cache_way_hit,
    input logic               s1_valid
);
    logic req_d1, req_d2, real_d1, real_d2;

    // Delay line for the request strobe and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d1  <= 1'b0;
            req_d2  <= 1'b0;
            real_d1 <= 1'b0;
            real_d2 <= 1'b0;
        end else begin
            req_d1  <= req_valid;
            req_d2  <= req_d1;
            real_d1 <= req_valid && req_real;
            real_d2 <= real_d1;
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_d1 && !req_d2 |-> !rsp_valid)
        else $error("p_idle_after_reset_r1");

    p_two_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == req_d2)
        else $error("p_two_cycle_r2");

    p_tlb_miss_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_tlb_miss |-> !rsp_hit && !rsp_cache_miss)
        else $error("p_tlb_miss_alone_r4");

    p_phys_no_tlb_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        real_d2 |-> !rsp_tlb_miss)
        else $error("p_phys_no_tlb_miss_r6");

    p_single_tlb_way_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tlb_way_hit))
        else $error("p_single_tlb_way_r8");

    p_single_cache_way_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> $onehot0(cache_way_hit))
        else $error("p_single_cache_way_r8");

    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsp_hit, rsp_tlb_miss, rsp_cache_miss}) == (rsp_valid ? 1 : 0))
        else $error("p_one_outcome_r9");

    p_miss_data_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> rsp_data == '0)
        else $error("p_miss_data_zero_r9");

endmodule

bind xlat_tag_lookup xlat_tag_lookup_chk #(
    .N_TLB   (N_TLB),
    .M_CACHE (M_CACHE),
    .DATA_W  (DATA_W)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_real       (req_real),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_tlb_miss   (rsp_tlb_miss),
    .rsp_cache_miss (rsp_cache_miss),
    .rsp_data       (rsp_data),
    .tlb_way_hit    (tlb_way_hit),
    .cache_way_hit  (cache_way_hit),
    .s1_valid       (s1_valid)
);

// File: tb/test_xlat_tag_lookup.sv
// Bench for xlat_tag_lookup: vector table walk, random stream against a
// model of the arrays, then directed reset, timing and invalidation cases.
module test_xlat_tag_lookup;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_real = 1'b0;
    logic        tlb_wr_en = 1'b0;
    logic [0:0]  tlb_wr_way = '0;
    logic [31:0] tlb_wr_vaddr = '0;
    logic [19:0] tlb_wr_ppn = '0;
    logic        tlb_wr_valid = 1'b0;
    logic        tag_wr_en = 1'b0;
    logic [0:0]  tag_wr_way = '0;
    logic [31:0] tag_wr_paddr = '0;
    logic        tag_wr_valid = 1'b0;
    logic [31:0] tag_wr_data = '0;
    logic        rsp_valid, rsp_hit, rsp_tlb_miss, rsp_cache_miss;
    logic [0:0]  rsp_way;
    logic [31:0] rsp_data;

    always #5 clk = ~clk;

    xlat_tag_lookup i_xlat_tag_lookup (.*);

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model of the arrays (default geometry).
    bit          m_tv   [16][2];
    logic [15:0] m_tvt  [16][2];
    logic [19:0] m_tppn [16][2];
    bit          m_cv   [64][2];
    logic [19:0] m_ctag [64][2];
    logic [31:0] m_cdat [64][2];

    // Expected result {kind, way, data}; kind 0 hit, 1 tlb miss, 2 cache miss.
    function automatic logic [34:0] model(logic [31:0] a, bit phys);
        logic [19:0] ppn = a[31:12];
        bit          th  = phys;
        if (!phys)
            for (int n = 0; n < 2; n++)
                if (m_tv[a[15:12]][n] && m_tvt[a[15:12]][n] == a[31:16]) begin
                    th  = 1;
                    ppn = m_tppn[a[15:12]][n];
                end
        if (!th) return {2'd1, 1'b0, 32'h0};
        for (int m = 0; m < 2; m++)
            if (m_cv[a[8:3]][m] && m_ctag[a[8:3]][m] == ppn)
                return {2'd0, 1'(m), m_cdat[a[8:3]][m]};
        return {2'd2, 1'b0, 32'h0};
    endfunction

    task automatic check_rsp(string req, logic [34:0] e);
        logic [36:0] act, exp;
        act = {rsp_valid, rsp_hit, rsp_tlb_miss, rsp_cache_miss, rsp_way, rsp_data};
        exp = {1'b1, e[34:33] == 2'd0, e[34:33] == 2'd1, e[34:33] == 2'd2, e[32:0]};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_eq(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tlb_write(int way, logic [31:0] va, logic [19:0] ppn, bit v);
        @(negedge clk);
        tlb_wr_en = 1; tlb_wr_way = 1'(way); tlb_wr_vaddr = va;
        tlb_wr_ppn = ppn; tlb_wr_valid = v;
        m_tv[va[15:12]][way] = v; m_tvt[va[15:12]][way] = va[31:16];
        m_tppn[va[15:12]][way] = ppn;
        @(negedge clk);
        tlb_wr_en = 0;
    endtask

    task automatic tag_write(int way, logic [31:0] pa, bit v, logic [31:0] d);
        @(negedge clk);
        tag_wr_en = 1; tag_wr_way = 1'(way); tag_wr_paddr = pa;
        tag_wr_valid = v; tag_wr_data = d;
        m_cv[pa[8:3]][way] = v; m_ctag[pa[8:3]][way] = pa[31:12];
        m_cdat[pa[8:3]][way] = d;
        @(negedge clk);
        tag_wr_en = 0;
    endtask

    // Single request; response checked in the cycle after the second edge.
    task automatic lookup(string req, logic [31:0] a, bit phys);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_real = phys;
        @(negedge clk);
        req_valid = 0; req_real = 0;
        @(negedge clk);
        check_rsp(req, model(a, phys));
    endtask

    // Stimulus table: {req number, phys, addr, kind, way, data}.
    localparam logic [71:0] VEC [10] = '{
        {4'd3, 1'b0, 32'h0001_1028, 2'd0, 1'b0, 32'h1111_0000}, // R3 tlb way0 -> cache way0
        {4'd7, 1'b0, 32'h0002_1028, 2'd0, 1'b1, 32'h2222_0001}, // R7 way0 row ignored
        {4'd3, 1'b0, 32'h0003_2030, 2'd0, 1'b1, 32'h3333_0002}, // R3
        {4'd5, 1'b0, 32'h0003_2028, 2'd2, 1'b0, 32'h0},         // R5
        {4'd4, 1'b0, 32'h0004_1028, 2'd1, 1'b0, 32'h0},         // R4 cache valid yet tlb miss
        {4'd4, 1'b0, 32'h0001_2028, 2'd1, 1'b0, 32'h0},         // R4 tag in other set
        {4'd6, 1'b1, 32'h1234_5030, 2'd0, 1'b0, 32'h4444_0003}, // R6
        {4'd6, 1'b1, 32'h00AA_A028, 2'd0, 1'b0, 32'h1111_0000}, // R6
        {4'd6, 1'b1, 32'h0001_1028, 2'd2, 1'b0, 32'h0},         // R6 would hit if translated
        {4'd5, 1'b0, 32'h0002_1030, 2'd2, 1'b0, 32'h0}          // R5
    };

    logic [31:0] s_addr [256];
    bit          s_phys [256];
    logic [34:0] s_exp  [256];
    string       s_req  [256];

    // Back-to-back issue; request j is checked while request j+2 is driven (R2).
    task automatic run_stream(int count);
        for (int j = 0; j < count + 2; j++) begin
            @(negedge clk);
            if (j >= 2) check_rsp(s_req[j-2], s_exp[j-2]);
            if (j < count) begin
                req_valid = 1; req_addr = s_addr[j]; req_real = s_phys[j];
            end else begin
                req_valid = 0; req_real = 0;
            end
        end
    endtask

    bit done = 0;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle outputs after reset.
        check_eq("R1 idle", {rsp_valid, rsp_hit, rsp_tlb_miss, rsp_cache_miss},
                 4'b0000);
        lookup("R1 translated after reset", 32'h0001_1028, 0);
        lookup("R1 phys after reset", 32'h00AA_A028, 1);

        tlb_write(0, 32'h0001_1000, 20'h00AAA, 1);
        tlb_write(1, 32'h0002_1000, 20'h00BBB, 1);
        tlb_write(1, 32'h0003_2000, 20'h00CCC, 1);
        tag_write(0, 32'h00AA_A028, 1, 32'h1111_0000);
        tag_write(1, 32'h00BB_B028, 1, 32'h2222_0001);
        tag_write(1, 32'h00CC_C030, 1, 32'h3333_0002);
        tag_write(0, 32'h1234_5030, 1, 32'h4444_0003);

        // Table walk, back to back.
        for (int i = 0; i < 10; i++) begin
            s_addr[i] = VEC[i][66:35];
            s_phys[i] = VEC[i][67];
            s_exp[i]  = VEC[i][34:0];
            s_req[i]  = $sformatf("R%0d table %0d", VEC[i][71:68], i);
        end
        run_stream(10);

        // Random stream against the model (R2 R3 R4 R5 R6).
        for (int j = 0; j < 200; j++) begin
            logic [19:0] pl [5] = '{20'h00AAA, 20'h00BBB, 20'h00CCC, 20'h12345, 20'h00011};
            logic [5:0]  cs = ($urandom % 2 == 0) ? 6'd5 : 6'd6;
            s_phys[j] = ($urandom % 4 == 0);
            if (s_phys[j])
                s_addr[j] = {pl[$urandom % 5], 3'b000, cs, 3'($urandom)};
            else
                s_addr[j] = {16'(1 + $urandom % 4), 4'(1 + $urandom % 2), 3'b000,
                             cs, 3'($urandom)};
            s_exp[j] = model(s_addr[j], s_phys[j]);
            s_req[j] = $sformatf("R2 random %0d", j);
        end
        run_stream(200);

        // R2: a lone request gives a one-cycle response pulse after two edges.
        @(negedge clk);
        req_valid = 1; req_addr = 32'h0003_2030; req_real = 0;
        @(negedge clk);
        req_valid = 0;
        check_eq("R2 not yet after one edge", rsp_valid, 1'b0);
        @(negedge clk);
        check_rsp("R2 lone request", {2'd0, 1'b1, 32'h3333_0002});
        @(negedge clk);
        check_eq("R2 pulse ends", rsp_valid, 1'b0);

        // R9: miss returns zero way and data and a single flag.
        lookup("R9 miss zero data", 32'h0003_2028, 0);

        // R8: invalidate and rewrite entries.
        tag_write(0, 32'h00AA_A028, 0, 32'hDEAD_BEEF);
        lookup("R8 invalid tag no match", 32'h0001_1028, 0);
        check_eq("R8 invalid tag is cache miss", rsp_cache_miss, 1'b1);
        tlb_write(1, 32'h0002_1000, 20'h00BBB, 0);
        lookup("R8 invalid tlb no match", 32'h0002_1028, 0);
        check_eq("R8 invalid tlb is tlb miss", rsp_tlb_miss, 1'b1);
        tag_write(0, 32'h0FFF_F028, 1, 32'h5555_AAAA);
        lookup("R8 rewritten line", 32'h0FFF_F028, 1);
        check_eq("R8 rewritten data", rsp_data, 32'h5555_AAAA);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule